// File: doc/BRIEF.md
# Keyboard Matrix Emulation Engine

This block stands in for a physical key matrix in front of a host keyboard scanner. The host drives a vector of strobe (column) lines and reads back a vector of sense (row) lines. Each sense line answers at once whether any key held down in its row lies on a strobe line that is currently asserted. The block keeps one pressed-key bitmap per row, indexed by column.

Key events arrive as byte codes on a valid/code input. A code carries a release flag, a row and a column. Valid codes enter a small circular queue. A clock divider produces a slow tick, and on each tick at most one queued event is taken and applied. Rate-limiting the events this way gives a polling scanner time to see every change. Events in the reserved special row do not touch the matrix. Each one drives one of a few dedicated side outputs, whose level is the press state XOR a per-line inversion bit.

A synchronous clear input releases every key and empties the queue, which matches a restore of the block's state. The sense lines follow the cleared bitmaps directly.

Top module: `keymat_engine`

## Requirements
- R1: `sense[i]` is high exactly when row i's bitmap ANDed with `strobe` is non-zero. It follows `strobe` and the bitmaps combinationally, with no clock delay.
- R2: An event byte is encoded as bit 7 = release (1) or press (0), bits 6:4 = row, bits 3:0 = column. Applying a press sets that key's bit and applying a release clears it. No other key changes.
- R3: An event with row 7 and low nibble n < 5 does not change the matrix. When it is applied, `special_out[n]` becomes (press XOR `invert_mask[n]`), using the mask value at that tick. The output then holds until the next event for line n.
- R4: An event whose position is invalid is dropped at the input and never occupies the queue. Invalid means row < 7 with column >= 11, or row 7 with low nibble >= 5.
- R5: The queue holds up to 16 events and applies them in arrival order. A later event for the same key wins.
- R6: `q_full` is high while 16 events are held. A push seen while `q_full` is high is rejected and has no effect.
- R7: A tick occurs once every TICK_DIV clock cycles. Exactly one queued event is applied per tick while the queue is non-empty, and the bitmaps change at no other time except a clear.
- R8: A cycle with `clr_all` high clears every row bitmap and empties the queue at the next edge. The special outputs keep their levels.
- R9: After reset all bitmaps are zero, the queue is empty, `q_full` is low and `special_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_all | input | 1 | Synchronous release-all and queue flush |
| evt_valid | input | 1 | Event code is present this cycle |
| evt_code | input | 8 | Event byte: release flag, row, column |
| invert_mask | input | NUM_SPECIAL (5) | Per-line inversion of the special outputs |
| strobe | input | NUM_STROBE (11) | Column strobes from the host scanner |
| sense | output | NUM_SENSE (7) | Row sense lines to the host scanner |
| special_out | output | NUM_SPECIAL (5) | Dedicated outputs driven by row-7 events |
| q_full | output | 1 | Event queue holds its maximum count |

## Verification
The sense function is probed two ways. Single-column strobes read back each bitmap column separately, which catches swapped row or column indexing. Random multi-column strobes test the OR across columns. Short random bursts mix presses, releases, special-row events and invalid codes under changing inversion masks, and the bench model is compared with the result after each burst drains. Directed sequences cover the remaining properties. Back-to-back pushes are sampled at tick boundaries to show one event per tick. Press/release pairs on one key test ordering. Invalid codes placed ahead of a valid one show that they take no queue slot. A fill to the full mark shows that the overflow push is lost. A clear issued with events still pending shows that nothing is applied afterwards.

// File: rtl/keymat_pkg.sv
package keymat_pkg;

    localparam int EVT_W = 8;

    // Event byte layout; the field positions are part of the interface
    typedef struct packed {
        logic       rel;
        logic [2:0] row;
        logic [3:0] col;
    } key_evt_t;

endpackage

// File: rtl/keymat_tick.sv
module keymat_tick #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = (st_q.cnt == LAST);
        st_d.cnt  = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    generate
        if (DIV > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R7
        end
    endgenerate

endmodule

// File: rtl/keymat_fifo.sv
module keymat_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic push_ok, pop_ok;

    assign full    = (st_q.cnt == CNT_MAX);
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = st_q.mem[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + 1'b1;
            end
            if (pop_ok) begin
                st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !clr) |=> full); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX); // R5

endmodule

// File: rtl/keymat_sense.sv
module keymat_sense #(
    parameter int NR = 7,
    parameter int NC = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NR-1:0][NC-1:0] rows,
    input  logic [NC-1:0]         strobe,
    output logic [NR-1:0]         sense
);
    generate
        for (genvar i = 0; i < NR; i++) begin : g_row
            assign sense[i] = |(rows[i] & strobe);
        end
    endgenerate

    AST_SENSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe == '0) |-> (sense == '0)); // R1
    AST_SENSE_NOKEY: assert property (@(posedge clk) disable iff (!rst_n)
        (rows == '0) |-> (sense == '0)); // R1

endmodule

// File: rtl/keymat_engine.sv
module keymat_engine #(
    parameter int          NUM_STROBE  = 11,
    parameter int          NUM_SENSE   = 7,
    parameter int          NUM_SPECIAL = 5,
    parameter int          QUEUE_DEPTH = 16,
    parameter int unsigned TICK_DIV    = 7812500
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_all,
    input  logic                   evt_valid,
    input  logic [7:0]             evt_code,
    input  logic [NUM_SPECIAL-1:0] invert_mask,
    input  logic [NUM_STROBE-1:0]  strobe,
    output logic [NUM_SENSE-1:0]   sense,
    output logic [NUM_SPECIAL-1:0] special_out,
    output logic                   q_full
);
    import keymat_pkg::*;

    localparam logic [2:0] SPECIAL_ROW = 3'(NUM_SENSE);
    localparam logic [3:0] COL_LIMIT   = 4'(NUM_STROBE);
    localparam logic [3:0] SPC_LIMIT   = 4'(NUM_SPECIAL);

    typedef struct packed {
        logic [NUM_SENSE-1:0][NUM_STROBE-1:0] rows;
        logic [NUM_SPECIAL-1:0]               spec;
    } eng_st_t;

    eng_st_t    st_d, st_q;
    key_evt_t   in_evt, head_evt;
    logic [EVT_W-1:0] head_raw;
    logic       in_ok, push, pop, tick, q_empty;

    assign in_evt = key_evt_t'(evt_code);
    assign in_ok  = ((in_evt.row < SPECIAL_ROW) && (in_evt.col < COL_LIMIT)) ||
                    ((in_evt.row == SPECIAL_ROW) && (in_evt.col < SPC_LIMIT));
    assign push   = evt_valid && in_ok;
    assign pop    = tick && !q_empty && !clr_all;
    assign head_evt = key_evt_t'(head_raw);

    keymat_tick #(.DIV(TICK_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    keymat_fifo #(.DEPTH(QUEUE_DEPTH), .W(EVT_W)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_all),
        .push      (push),
        .push_data (evt_code),
        .pop       (pop),
        .head      (head_raw),
        .empty     (q_empty),
        .full      (q_full)
    );

    always_comb begin
        st_d = st_q;
        if (clr_all) begin
            st_d.rows = '0;
        end else if (pop) begin
            for (int r = 0; r < NUM_SENSE; r++) begin
                for (int c = 0; c < NUM_STROBE; c++) begin
                    if (head_evt.row == 3'(r) && head_evt.col == 4'(c))
                        st_d.rows[r][c] = !head_evt.rel;
                end
            end
            for (int n = 0; n < NUM_SPECIAL; n++) begin
                if (head_evt.row == SPECIAL_ROW && head_evt.col == 4'(n))
                    st_d.spec[n] = !head_evt.rel ^ invert_mask[n];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    keymat_sense #(.NR(NUM_SENSE), .NC(NUM_STROBE)) i_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .rows   (st_q.rows),
        .strobe (strobe),
        .sense  (sense)
    );

    assign special_out = st_q.spec;

    AST_APPLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr_all) |=> $stable(st_q.rows)); // R7
    AST_CLEAR_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (st_q.rows == '0)); // R8
    AST_SPECIAL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || clr_all) |=> $stable(st_q.spec)); // R3
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> !q_full); // R8

endmodule

// File: tb/test_keymat_engine.sv
module test_keymat_engine;

    localparam int NSTB = 11;
    localparam int NSNS = 7;
    localparam int NSPC = 5;
    localparam int QD   = 16;
    localparam int TDIV = 8;
    localparam int DRAIN = TDIV * (QD + 4);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clr_all = 1'b0;
    logic            evt_valid = 1'b0;
    logic [7:0]      evt_code = '0;
    logic [NSPC-1:0] invert_mask = '0;
    logic [NSTB-1:0] strobe = '0;
    logic [NSNS-1:0] sense;
    logic [NSPC-1:0] special_out;
    logic            q_full;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [NSNS-1:0][NSTB-1:0] exp_rows = '0;
    logic [NSPC-1:0]           exp_spec = '0;

    always #2 clk = ~clk;

    keymat_engine #(
        .NUM_STROBE(NSTB), .NUM_SENSE(NSNS), .NUM_SPECIAL(NSPC),
        .QUEUE_DEPTH(QD), .TICK_DIV(TDIV)
    ) i_keymat_engine (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
        .evt_valid(evt_valid), .evt_code(evt_code),
        .invert_mask(invert_mask), .strobe(strobe),
        .sense(sense), .special_out(special_out), .q_full(q_full)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NSNS-1:0] model_sense(input logic [NSTB-1:0] s);
        logic [NSNS-1:0] v;
        for (int r = 0; r < NSNS; r++) v[r] = |(exp_rows[r] & s);
        return v;
    endfunction

    function automatic bit code_valid(input logic [7:0] code);
        return (code[6:4] < 3'd7 && code[3:0] < 4'd11) ||
               (code[6:4] == 3'd7 && code[3:0] < 4'd5);
    endfunction

    task automatic model_apply(input logic [7:0] code);
        if (code[6:4] < 3'd7 && code[3:0] < 4'd11)
            exp_rows[code[6:4]][code[3:0]] = !code[7];
        else if (code[6:4] == 3'd7 && code[3:0] < 4'd5)
            exp_spec[code[3:0]] = !code[7] ^ invert_mask[code[3:0]];
    endtask

    task automatic push_one(input logic [7:0] code);
        evt_valid = 1'b1;
        evt_code  = code;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic check_matrix(input string req);
        bit ok = 1'b1;
        logic [31:0] act = '0, exp = '0;
        for (int c = 0; c < NSTB; c++) begin
            strobe = NSTB'(1) << c;
            @(negedge clk);
            if (sense != model_sense(strobe)) begin
                ok = 1'b0; act = 32'(sense); exp = 32'(model_sense(strobe));
            end
        end
        for (int k = 0; k < 4; k++) begin
            strobe = NSTB'($urandom);
            @(negedge clk);
            if (sense != model_sense(strobe)) begin
                ok = 1'b0; act = 32'(sense); exp = 32'(model_sense(strobe));
            end
        end
        chk(ok, req, act, exp);
    endtask

    task automatic drain();
        repeat (DRAIN) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        strobe = '1;
        @(negedge clk);
        chk(sense == '0, "R9 sense", 32'(sense), 0);
        chk(special_out == '0, "R9 special", 32'(special_out), 0);
        chk(q_full == 1'b0, "R9 q_full", 32'(q_full), 0);

        // R7: one event per tick, back-to-back pushes
        push_one(8'h00); push_one(8'h10); push_one(8'h20);
        repeat (6) @(negedge clk);
        chk($countones(sense) == 1, "R7 after one tick", 32'(sense), 1);
        repeat (TDIV) @(negedge clk);
        chk($countones(sense) == 2, "R7 after two ticks", 32'(sense), 2);
        repeat (TDIV) @(negedge clk);
        chk($countones(sense) == 3, "R7 after three ticks", 32'(sense), 3);
        model_apply(8'h00); model_apply(8'h10); model_apply(8'h20);

        // R5: ordering of press/release pairs
        push_one(8'h33); push_one(8'hB3); push_one(8'hC4); push_one(8'h44);
        model_apply(8'h33); model_apply(8'hB3); model_apply(8'hC4); model_apply(8'h44);
        drain();
        check_matrix("R5 order");

        // R2: release one key, neighbours untouched
        push_one(8'h90);
        model_apply(8'h90);
        drain();
        check_matrix("R2 release");

        // R4: invalid codes take no queue slot
        push_one(8'h0B); push_one(8'h7F); push_one(8'h75); push_one(8'h55);
        strobe = NSTB'(1) << 5;
        repeat (7) @(negedge clk);
        chk(sense[5] == 1'b1, "R4 valid after invalids", 32'(sense), 32'h20);
        model_apply(8'h55);
        drain();
        check_matrix("R4 no effect");
        chk(special_out == exp_spec, "R4 special", 32'(special_out), 32'(exp_spec));

        // R3: special row with inversion
        invert_mask = 5'b00101;
        push_one(8'h70); push_one(8'h71); push_one(8'hF2);
        model_apply(8'h70); model_apply(8'h71); model_apply(8'hF2);
        drain();
        chk(special_out == exp_spec, "R3 special levels", 32'(special_out), 32'(exp_spec));
        invert_mask = 5'b11010;
        repeat (3) @(negedge clk);
        chk(special_out == exp_spec, "R3 hold after mask change", 32'(special_out), 32'(exp_spec));
        check_matrix("R3 matrix untouched");

        // R8: clear with events pending
        push_one(8'h01); push_one(8'h62); push_one(8'h73);
        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
        exp_rows = '0;
        drain();
        check_matrix("R8 released");
        chk(special_out == exp_spec, "R8 special kept", 32'(special_out), 32'(exp_spec));
        chk(q_full == 1'b0, "R8 queue empty", 32'(q_full), 0);

        // R6: fill to full, overflow push lost
        begin
            int acc = 0;
            for (int k = 0; k < 30; k++) begin
                logic [7:0] c;
                if (q_full) break;
                c = {1'b0, 3'(k / 11), 4'(k % 11)};
                push_one(c);
                model_apply(c);
                acc++;
            end
            chk(q_full == 1'b1, "R6 full flag", 32'(q_full), 1);
            chk(acc >= QD && acc < 30, "R6 accepted count", 32'(acc), QD);
            push_one(8'h6A);
            drain();
            check_matrix("R6 overflow dropped");
        end

        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
        exp_rows = '0;

        // Random bursts: R1, R2, R3, R4
        for (int b = 0; b < 8; b++) begin
            int len;
            invert_mask = NSPC'($urandom);
            len = 1 + ($urandom % 10);
            for (int e = 0; e < len; e++) begin
                logic [7:0] c;
                logic [2:0] r;
                r = 3'($urandom % 8);
                if ($urandom % 5 == 0)
                    c = {1'($urandom), 3'($urandom % 7), 4'(11 + $urandom % 5)};
                else if (r == 3'd7)
                    c = {1'($urandom), r, 4'($urandom % 5)};
                else
                    c = {1'($urandom), r, 4'($urandom % 11)};
                push_one(c);
                if (code_valid(c)) model_apply(c);
            end
            drain();
            check_matrix("R1 random burst");
            chk(special_out == exp_spec, "R3 random special", 32'(special_out), 32'(exp_spec));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule